// File: doc/BRIEF.md
# Temperature Alarm Event Output

This block takes a stream of signed temperature samples and checks each accepted sample against three programmable limits: an upper window edge, a lower window edge and a critical ceiling. Each limit keeps a sticky status flag. The flag sets as soon as a sample is beyond its limit. It clears only once a sample has come back past the limit by a programmable hysteresis margin. Temperatures and limits are 13-bit two's complement numbers in steps of 1/16 °C.

The three flags drive a single alarm line, which has three behaviours. In comparator mode the line follows the flags, like a thermostat. In interrupt mode the line latches when the temperature crosses a window edge and stays set until the host clears it. The line can also be set to report only the critical condition. The critical condition cannot be cleared by the host while the temperature is still above the critical limit. The output is the enable of an open-drain pull-down, so it works with either polarity. The configuration and limits come from an external register file.

The sample input is a valid/ready stream. Ready is held high at all times, because each sample is handled in a single cycle and the block never applies back-pressure. A sample is accepted on a rising clock edge where valid is high. Temperature values present in any other cycle are ignored.

Top module: `thermal_event_out`

## Requirements
- R1: During and after reset, with no sample accepted yet, all three status flags read 0 and the interrupt latch is clear.
- R2: An accepted sample greater than the upper limit sets `st_above_upper` on that clock edge.
- R3: Hysteresis code `cfg_hyst` selects a margin of 0, 24, 48 or 96 LSB (code 0..3). A set upper or critical flag clears only on an accepted sample at or below its limit minus the margin.
- R4: An accepted sample below the lower limit sets `st_below_lower`. That flag clears only on an accepted sample at or above the lower limit plus the margin.
- R5: An accepted sample greater than the critical limit sets `st_above_crit`. It follows the same hysteresis rule as R3.
- R6: In comparator mode (`cfg_int_mode`=0, `cfg_crit_only`=0) the alarm is active exactly when any of the three flags is set.
- R7: In interrupt mode the alarm latches on a sample that newly sets the upper or lower flag. The latch holds after the flag clears and is released only by `clr_event`.
- R8: If `clr_event` arrives in the same cycle as a sample that newly sets the upper or lower flag, the new event wins and the latch stays set.
- R9: In interrupt mode the alarm stays active while `st_above_crit` is set, whatever `clr_event` does.
- R10: With `cfg_crit_only`=1 the alarm is active exactly when `st_above_crit` is set, in either mode.
- R11: `evt_pull_low` equals (alarm active XOR `cfg_active_high`). Alarm active is forced to 0 while `cfg_evt_en`=0, and that also clears the interrupt latch.
- R12: `smp_ready` is always 1. The flags change only on clock edges where `smp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Temperature sample valid |
| smp_ready | output | 1 | Always 1, no back-pressure |
| smp_temp | input | 13 | Signed sample, 1/16 °C per LSB |
| lim_upper | input | 13 | Upper window limit, signed |
| lim_lower | input | 13 | Lower window limit, signed |
| lim_crit | input | 13 | Critical limit, signed |
| cfg_evt_en | input | 1 | Alarm output enable |
| cfg_int_mode | input | 1 | 1 = latched interrupt, 0 = comparator |
| cfg_active_high | input | 1 | 1 = active-high alarm line |
| cfg_crit_only | input | 1 | Alarm reports only the critical flag |
| cfg_hyst | input | 2 | Hysteresis select, 0/24/48/96 LSB |
| clr_event | input | 1 | Clear the interrupt latch |
| evt_pull_low | output | 1 | Open-drain pull-down enable for the alarm pin |
| st_above_upper | output | 1 | Upper flag |
| st_below_lower | output | 1 | Lower flag |
| st_above_crit | output | 1 | Critical flag |

## Verification
The interesting overlap is a clear request landing in the same cycle as a sample that crosses a window edge. The test drives exactly that case on purpose, and random traffic also produces it. The expected result is a latch that is still set afterwards. A second overlap is a clear request while the critical flag is set: the pin must stay active even though the latch itself drops. A behavioural model in the test tracks the flags, the latch and the pin, and it is compared with the outputs on every clock.

// File: rtl/tas_pkg.sv
package tas_pkg;
  typedef enum logic {DIR_ABOVE = 1'b0, DIR_BELOW = 1'b1} dir_e;

  // hysteresis margin in LSB for a given fractional width
  function automatic int hyst_steps(input logic [1:0] code, input int frac);
    case (code)
      2'd0:    return 0;
      2'd1:    return 3 << (frac - 1);
      2'd2:    return 3 << frac;
      default: return 3 << (frac + 1);
    endcase
  endfunction
endpackage

// File: rtl/tas_limit_cmp.sv
module tas_limit_cmp #(
  parameter int TEMP_W = 13,
  parameter int FRAC_BITS = 4,
  parameter tas_pkg::dir_e DIR = tas_pkg::DIR_ABOVE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_fire,
  input  logic signed [TEMP_W-1:0] temp,
  input  logic signed [TEMP_W-1:0] limit,
  input  logic [1:0]               hyst_code,
  output logic                     flag,
  output logic                     flag_rise
);
  localparam int EW = TEMP_W + 2;

  logic signed [EW-1:0] t_x, l_x, h_x, edge_x;
  logic trip, hold, nxt;

  always_comb begin
    t_x = EW'(temp);
    l_x = EW'(limit);
    h_x = EW'(tas_pkg::hyst_steps(hyst_code, FRAC_BITS));
    if (DIR == tas_pkg::DIR_ABOVE) begin
      edge_x = l_x - h_x;
      trip   = t_x > l_x;
      hold   = t_x > edge_x;
    end else begin
      edge_x = l_x + h_x;
      trip   = t_x < l_x;
      hold   = t_x < edge_x;
    end
    nxt       = trip | (flag & hold);
    flag_rise = smp_fire & nxt & ~flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (smp_fire) flag <= nxt;
  end

  assert_hold_without_sample_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_fire |=> $stable(flag));
  // R2, R4, R5: a sample beyond the limit sets the flag
  assert_trip_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_fire && trip) |=> flag);
  // R3: inside the hysteresis band a set flag stays set
  assert_band_keeps_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_fire && flag && hold) |=> flag);
endmodule

// File: rtl/tas_event_latch.sv
module tas_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic set_req,
  input  logic clr_req,
  output logic lat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lat <= 1'b0;
    else if (!arm)    lat <= 1'b0;
    else if (set_req) lat <= 1'b1;
    else if (clr_req) lat <= 1'b0;
  end

  assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && lat && !clr_req) |=> lat);
  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && set_req) |=> lat);
  assert_disarm_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !lat);
endmodule

// File: rtl/thermal_event_out.sv
module thermal_event_out #(
  parameter int TEMP_W = 13,
  parameter int FRAC_BITS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  output logic                     smp_ready,
  input  logic signed [TEMP_W-1:0] smp_temp,
  input  logic signed [TEMP_W-1:0] lim_upper,
  input  logic signed [TEMP_W-1:0] lim_lower,
  input  logic signed [TEMP_W-1:0] lim_crit,
  input  logic                     cfg_evt_en,
  input  logic                     cfg_int_mode,
  input  logic                     cfg_active_high,
  input  logic                     cfg_crit_only,
  input  logic [1:0]               cfg_hyst,
  input  logic                     clr_event,
  output logic                     evt_pull_low,
  output logic                     st_above_upper,
  output logic                     st_below_lower,
  output logic                     st_above_crit
);
  localparam int NLIM = 3;

  logic smp_fire;
  logic signed [TEMP_W-1:0] lim_arr [NLIM];
  logic [NLIM-1:0] flags, rises;
  logic int_arm, lat, evt_active;

  assign smp_ready  = 1'b1;
  assign smp_fire   = smp_valid & smp_ready;
  assign lim_arr[0] = lim_upper;
  assign lim_arr[1] = lim_lower;
  assign lim_arr[2] = lim_crit;

  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    localparam tas_pkg::dir_e D = (g == 1) ? tas_pkg::DIR_BELOW : tas_pkg::DIR_ABOVE;
    tas_limit_cmp #(.TEMP_W(TEMP_W), .FRAC_BITS(FRAC_BITS), .DIR(D)) u_cmp (
      .clk(clk), .rst_n(rst_n), .smp_fire(smp_fire), .temp(smp_temp),
      .limit(lim_arr[g]), .hyst_code(cfg_hyst),
      .flag(flags[g]), .flag_rise(rises[g])
    );
  end

  assign int_arm = cfg_evt_en & cfg_int_mode & ~cfg_crit_only;

  tas_event_latch u_latch (
    .clk(clk), .rst_n(rst_n), .arm(int_arm),
    .set_req(rises[0] | rises[1]), .clr_req(clr_event), .lat(lat)
  );

  always_comb begin
    if (!cfg_evt_en)       evt_active = 1'b0;
    else if (cfg_crit_only) evt_active = flags[2];
    else if (cfg_int_mode)  evt_active = lat | flags[2];
    else                    evt_active = |flags;
  end

  assign evt_pull_low   = evt_active ^ cfg_active_high;
  assign st_above_upper = flags[0];
  assign st_below_lower = flags[1];
  assign st_above_crit  = flags[2];

  assert_crit_unclearable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_arm && st_above_crit) |-> evt_active);
  assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_evt_en |-> (evt_pull_low == cfg_active_high));
  assert_crit_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_evt_en && cfg_crit_only && !st_above_crit) |-> !evt_active);
  assert_comparator_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_evt_en && !cfg_int_mode && !cfg_crit_only && (st_above_upper || st_below_lower))
      |-> evt_active);
endmodule

// File: tb/thermal_event_out_test.sv
module thermal_event_out_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0, clr_event = 1'b0;
  logic signed [12:0] smp_temp = '0, lim_upper = '0, lim_lower = '0, lim_crit = '0;
  logic cfg_evt_en = 0, cfg_int_mode = 0, cfg_active_high = 0, cfg_crit_only = 0;
  logic [1:0] cfg_hyst = 2'd0;
  logic smp_ready, evt_pull_low, st_above_upper, st_below_lower, st_above_crit;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";
  int m_au = 0, m_bl = 0, m_cr = 0, m_lat = 0;
  int seed = 7;

  always #10 clk = ~clk;

  thermal_event_out uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_temp(smp_temp), .lim_upper(lim_upper), .lim_lower(lim_lower),
    .lim_crit(lim_crit), .cfg_evt_en(cfg_evt_en), .cfg_int_mode(cfg_int_mode),
    .cfg_active_high(cfg_active_high), .cfg_crit_only(cfg_crit_only),
    .cfg_hyst(cfg_hyst), .clr_event(clr_event), .evt_pull_low(evt_pull_low),
    .st_above_upper(st_above_upper), .st_below_lower(st_below_lower),
    .st_above_crit(st_above_crit)
  );

  function automatic int hmargin(input int code);
    if (code == 0) return 0;
    if (code == 1) return 24;
    if (code == 2) return 48;
    return 96;
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_au = 0; m_bl = 0; m_cr = 0; m_lat = 0;
    end else begin
      int t, h, nau, nbl, ncr, rise, arm;
      t = int'(smp_temp);
      h = hmargin(int'(cfg_hyst));
      nau = m_au; nbl = m_bl; ncr = m_cr; rise = 0;
      if (smp_valid) begin
        nau = (t > int'(lim_upper)) || (m_au != 0 && t > int'(lim_upper) - h);
        nbl = (t < int'(lim_lower)) || (m_bl != 0 && t < int'(lim_lower) + h);
        ncr = (t > int'(lim_crit))  || (m_cr != 0 && t > int'(lim_crit) - h);
        rise = (nau != 0 && m_au == 0) || (nbl != 0 && m_bl == 0);
      end
      arm = cfg_evt_en && cfg_int_mode && !cfg_crit_only;
      if (!arm) m_lat = 0;
      else if (rise != 0) m_lat = 1;
      else if (clr_event) m_lat = 0;
      m_au = nau; m_bl = nbl; m_cr = ncr;
    end
  end

  function automatic int model_pull();
    int act;
    if (!cfg_evt_en) act = 0;
    else if (cfg_crit_only) act = m_cr;
    else if (cfg_int_mode) act = (m_lat != 0 || m_cr != 0);
    else act = (m_au != 0 || m_bl != 0 || m_cr != 0);
    return (act != 0) ^ cfg_active_high;
  endfunction

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("st_above_upper", int'(st_above_upper), m_au);
    check("st_below_lower", int'(st_below_lower), m_bl);
    check("st_above_crit", int'(st_above_crit), m_cr);
    check("evt_pull_low", int'(evt_pull_low), model_pull());
    check("smp_ready", int'(smp_ready), 1);
  endtask

  // one clock: inputs already set, compare 5 ns after the edge
  task automatic tick();
    @(posedge clk);
    #5;
    compare_all();
  endtask

  task automatic sample(input int t, input bit clr = 0);
    smp_temp = 13'(t); smp_valid = 1'b1; clr_event = clr;
    tick();
    smp_valid = 1'b0; clr_event = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) tick();
    check("reset pull", int'(evt_pull_low), 0);
    rst_n = 1'b1;
    tick(); tick();
    check("reset upper flag", int'(st_above_upper), 0);

    lim_upper = 13'sd1360; lim_lower = 13'sd320; lim_crit = 13'sd1520;
    cfg_evt_en = 1'b1;

    cur_req = "R2";
    sample(800);
    sample(1376);
    check("upper set", int'(st_above_upper), 1);

    cur_req = "R12";
    smp_temp = 13'sd0; tick(); tick();
    check("no sample, upper held", int'(st_above_upper), 1);

    cur_req = "R3";
    cfg_hyst = 2'd1;
    sample(1350);
    check("inside band", int'(st_above_upper), 1);
    sample(1336);
    check("band exit", int'(st_above_upper), 0);

    cur_req = "R4";
    sample(300);
    check("lower set", int'(st_below_lower), 1);
    sample(330);
    sample(344);
    check("lower clear", int'(st_below_lower), 0);

    cur_req = "R5";
    cfg_hyst = 2'd3;
    sample(1530);
    sample(1430);
    check("crit in band", int'(st_above_crit), 1);
    sample(1424);
    check("crit clear", int'(st_above_crit), 0);

    cur_req = "R6";
    sample(1400);
    check("comparator pull", int'(evt_pull_low), 1);
    sample(800);
    check("comparator release", int'(evt_pull_low), 0);

    cur_req = "R7";
    cfg_hyst = 2'd0; cfg_int_mode = 1'b1;
    sample(1400);
    sample(800);
    check("latched after return", int'(evt_pull_low), 1);
    clr_event = 1'b1; tick(); clr_event = 1'b0;
    check("cleared", int'(evt_pull_low), 0);

    cur_req = "R8";
    sample(100, 1'b1);
    check("set beats clear", int'(evt_pull_low), 1);
    clr_event = 1'b1; tick(); clr_event = 1'b0;
    sample(800);

    cur_req = "R9";
    sample(1600);
    clr_event = 1'b1; tick(); tick(); clr_event = 1'b0;
    check("crit not clearable", int'(evt_pull_low), 1);
    sample(800);
    check("crit gone", int'(evt_pull_low), 0);

    cur_req = "R10";
    cfg_crit_only = 1'b1;
    sample(1400);
    check("window ignored", int'(evt_pull_low), 0);
    sample(1530);
    check("crit reported", int'(evt_pull_low), 1);
    cfg_int_mode = 1'b0; tick();
    sample(800);

    cur_req = "R11";
    cfg_crit_only = 1'b0; cfg_active_high = 1'b1;
    sample(1400);
    check("active high asserted", int'(evt_pull_low), 0);
    cfg_evt_en = 1'b0; tick();
    check("disabled", int'(evt_pull_low), 1);
    cfg_active_high = 1'b0; tick();
    cfg_evt_en = 1'b1; sample(800);

    cur_req = "R8";
    for (int i = 0; i < 2000; i++) begin
      if (i % 64 == 0) begin
        seed = seed * 1103515245 + 12345;
        cfg_int_mode    = seed[16];
        cfg_active_high = seed[17];
        cfg_crit_only   = (seed[20:18] == 3'd0);
        cfg_evt_en      = (seed[23:21] != 3'd0);
        cfg_hyst        = seed[25:24];
      end
      seed = seed * 1103515245 + 12345;
      smp_valid = seed[20];
      clr_event = (seed[23:21] == 3'd0);
      smp_temp  = 13'(200 + int'(seed[30:20]) % 1500);
      tick();
    end
    smp_valid = 1'b0; clr_event = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule